// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block sits between a processor bus and banked program and pattern memories. Software writes a one-byte select register and sixteen one-byte bank numbers through four write decodes in the upper half of the processor address space. The block then turns every processor program address (0x8000–0xFFFF) and every pattern address (0x0000–0x1FFF) into a physical address: a bank number followed by the offset inside the window.

Program space is cut into four 8 KB windows. The top window always points at the last bank. The other three take their bank numbers from registers 6, 7 and 15, and one mode bit rotates which window gets which register. Pattern space is cut into eight 1 KB windows. A second mode bit exchanges the lower and upper 4 KB halves. A third mode bit picks one of two schemes: either registers 8 and 9 supply windows 1 and 3 directly, or those windows follow on from the bank of the window before them as the second half of a 2 KB pair. A separate write sets one nametable mirroring bit.

Both physical addresses are registered. Each one reflects the address presented one clock earlier, looked up in the register contents as they stood before that edge.

Top module: `bankmap_top`

## Requirements
- R1: After synchronous reset the select register, all sixteen bank registers and the mirroring bit are zero. A program lookup at 0x8000 then gives physical 0, and a pattern lookup at 0x0400 gives bank 1.
- R2: A write is decoded on the address ANDed with 0xE001. A result of 0x8000 loads the select register. A result of 0x8001 loads bank register number select[3:0]. Aliases such as 0x9FFF decode the same way.
- R3: For program windows 0, 1 and 2 (address bits 14:13 = 0, 1, 2) the bank comes from registers 6, 7 and 15 when select bit 6 is 0, and from registers 15, 6 and 7 when select bit 6 is 1.
- R4: Program window 3 (0xE000–0xFFFF) always uses bank 0xFF, the all-ones bank number.
- R5: Logical pattern windows 0, 2, 4, 5, 6 and 7 use registers 0, 1, 2, 3, 4 and 5. Logical windows 1 and 3 use registers 8 and 9 when select bit 5 is 1, and register 0 plus 1 and register 1 plus 1 when it is 0.
- R6: When select bit 7 is 1, the logical pattern window is the window number (address bits 12:10) XOR 4.
- R7: A write whose decoded address is 0xA000 sets the mirroring output to data bit 0 (1 = horizontal, 0 = vertical).
- R8: Writes whose decoded address is 0xA001, 0xC000, 0xC001, 0xE000 or 0xE001, and writes below 0x8000, change no register and do not change the mirroring bit.
- R9: The program output is {bank[7:0], address[12:0]} and the pattern output is {bank[7:0], address[9:0]}. Each is registered, one clock after the address.
- R10: The "plus 1" of paired pattern banking wraps modulo 256, so register 0 = 0xFF gives bank 0x00 for logical window 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | 16 | Processor address, used for both register writes and program lookup |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_data_i | input | 8 | Processor write data |
| pat_addr_i | input | 13 | Pattern address to translate |
| prg_phys_o | output | 21 | Registered physical program address |
| pat_phys_o | output | 18 | Registered physical pattern address |
| mirror_h_o | output | 1 | Mirroring control, 1 = horizontal |

## Verification
The hardest state to reach from the ports is the one where both select bit 7 and select bit 5 are set. There, the physical pattern windows 5 and 7 are fed by registers 8 and 9 through the half swap. This only shows up if every register holds a distinct value, and register 9 is loaded through an alias address. The stimulus first fills all sixteen registers with distinct values, then steps the select register through every combination of mode bits, probing each window with a nonzero offset. A wrap case with register 0 at 0xFF covers the carry out of the paired bank.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  localparam int CPU_ADDR_W = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SEL  = 2'd1,
    OP_DATA = 2'd2,
    OP_MIRR = 2'd3
  } reg_op_e;

  localparam logic [CPU_ADDR_W-1:0] DEC_MASK = 16'hE001;
  localparam logic [CPU_ADDR_W-1:0] DEC_SEL  = 16'h8000;
  localparam logic [CPU_ADDR_W-1:0] DEC_DATA = 16'h8001;
  localparam logic [CPU_ADDR_W-1:0] DEC_MIRR = 16'hA000;

  // Mode bit positions inside the select register
  localparam int MODE_PAT_FULL = 5;
  localparam int MODE_PRG_SWAP = 6;
  localparam int MODE_PAT_INV  = 7;

  // Bank registers feeding the movable program windows
  localparam int PRG_REG_A = 6;
  localparam int PRG_REG_B = 7;
  localparam int PRG_REG_C = 15;

  function automatic reg_op_e decode_op(input logic wr,
                                        input logic [CPU_ADDR_W-1:0] addr);
    logic [CPU_ADDR_W-1:0] m;
    m = addr & DEC_MASK;
    if (!wr)                 return OP_NONE;
    else if (m == DEC_SEL)   return OP_SEL;
    else if (m == DEC_DATA)  return OP_DATA;
    else if (m == DEC_MIRR)  return OP_MIRR;
    else                     return OP_NONE;
  endfunction

endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
  import bankmap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [CPU_ADDR_W-1:0]           addr_i,
  input  logic                            wr_i,
  input  logic [DATA_W-1:0]               data_i,
  output logic [DATA_W-1:0]               sel_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0] bank_o,
  output logic                            mirror_h_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  reg_op_e op;
  assign op = decode_op(wr_i, addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o      <= '0;
      mirror_h_o <= 1'b0;
    end else begin
      if (op == OP_SEL)  sel_o      <= data_i;
      if (op == OP_MIRR) mirror_h_o <= data_i[0];
    end
  end

  // One write enable per bank register
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_o[g] <= '0;
      else if (op == OP_DATA && sel_o[IDX_W-1:0] == IDX_W'(g))
        bank_o[g] <= data_i;
    end
  end

  a_r2_data_write: assert property (@(posedge clk) disable iff (rst)
    (wr_i && ((addr_i & DEC_MASK) == DEC_DATA))
      |=> bank_o[$past(sel_o[IDX_W-1:0])] == $past(data_i));

  a_r7_mirror_load: assert property (@(posedge clk) disable iff (rst)
    (wr_i && ((addr_i & DEC_MASK) == DEC_MIRR))
      |=> mirror_h_o == $past(data_i[0]));

  a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && ((addr_i & DEC_MASK) == DEC_SEL)) |=> $stable(sel_o));

  a_r8_mirror_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && ((addr_i & DEC_MASK) == DEC_MIRR)) |=> $stable(mirror_h_o));

endmodule

// File: rtl/bankmap_prg_xlat.sv
module bankmap_prg_xlat
  import bankmap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int OFS_W    = 13
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [CPU_ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]               sel_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_i,
  output logic [DATA_W+OFS_W-1:0]         phys_o
);
  localparam logic [DATA_W-1:0] LAST_BANK = '1;

  logic [1:0]        win;
  logic [DATA_W-1:0] bank_sel;
  logic              swap;

  assign win  = addr_i[OFS_W+1:OFS_W];
  assign swap = sel_i[MODE_PRG_SWAP];

  always_comb begin
    unique case (win)
      2'd0:    bank_sel = swap ? bank_i[PRG_REG_C] : bank_i[PRG_REG_A];
      2'd1:    bank_sel = swap ? bank_i[PRG_REG_A] : bank_i[PRG_REG_B];
      2'd2:    bank_sel = swap ? bank_i[PRG_REG_B] : bank_i[PRG_REG_C];
      default: bank_sel = LAST_BANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phys_o <= '0;
    else     phys_o <= {bank_sel, addr_i[OFS_W-1:0]};
  end

  a_r4_last_window: assert property (@(posedge clk) disable iff (rst)
    (addr_i[OFS_W+1:OFS_W] == 2'd3) |=> phys_o[DATA_W+OFS_W-1:OFS_W] == LAST_BANK);

  a_r9_prg_offset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phys_o[OFS_W-1:0] == $past(addr_i[OFS_W-1:0]));

endmodule

// File: rtl/bankmap_pat_xlat.sv
module bankmap_pat_xlat
  import bankmap_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int OFS_W    = 10,
  parameter int WIN_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [WIN_W+OFS_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]               sel_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_i,
  output logic [DATA_W+OFS_W-1:0]         phys_o
);
  localparam int NUM_WIN  = 1 << WIN_W;
  localparam int HALF_WIN = NUM_WIN / 2;

  logic [DATA_W-1:0] logical_bank [NUM_WIN];
  logic [WIN_W-1:0]  phys_win, log_win;
  logic              full_mode;

  assign full_mode = sel_i[MODE_PAT_FULL];
  assign phys_win  = addr_i[WIN_W+OFS_W-1:OFS_W];
  assign log_win   = phys_win ^ {sel_i[MODE_PAT_INV], {(WIN_W-1){1'b0}}};

  // Bank for each logical window: odd lower windows are the pair halves
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    if (k < HALF_WIN && (k % 2) == 1) begin : g_pair
      assign logical_bank[k] = full_mode ? bank_i[8 + k/2]
                                         : bank_i[k/2] + DATA_W'(1);
    end else if (k < HALF_WIN) begin : g_low
      assign logical_bank[k] = bank_i[k/2];
    end else begin : g_high
      assign logical_bank[k] = bank_i[k - 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phys_o <= '0;
    else     phys_o <= {logical_bank[log_win], addr_i[OFS_W-1:0]};
  end

  a_r9_pat_offset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phys_o[OFS_W-1:0] == $past(addr_i[OFS_W-1:0]));

  a_r6_even_low_window: assert property (@(posedge clk) disable iff (rst)
    (addr_i[WIN_W+OFS_W-1:OFS_W] == '0 && !sel_i[MODE_PAT_INV])
      |=> phys_o[DATA_W+OFS_W-1:OFS_W] == $past(bank_i[0]));

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 16,
  parameter int PRG_OFS_W  = 13,
  parameter int PAT_OFS_W  = 10,
  parameter int PAT_WIN_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [15:0]                     cpu_addr_i,
  input  logic                            cpu_wr_i,
  input  logic [DATA_W-1:0]               cpu_data_i,
  input  logic [PAT_WIN_W+PAT_OFS_W-1:0]  pat_addr_i,
  output logic [DATA_W+PRG_OFS_W-1:0]     prg_phys_o,
  output logic [DATA_W+PAT_OFS_W-1:0]     pat_phys_o,
  output logic                            mirror_h_o
);
  logic [DATA_W-1:0]               sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank;

  bankmap_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (cpu_addr_i),
    .wr_i       (cpu_wr_i),
    .data_i     (cpu_data_i),
    .sel_o      (sel),
    .bank_o     (bank),
    .mirror_h_o (mirror_h_o)
  );

  bankmap_prg_xlat #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .OFS_W(PRG_OFS_W)) prg_i (
    .clk    (clk),
    .rst    (rst),
    .addr_i (cpu_addr_i),
    .sel_i  (sel),
    .bank_i (bank),
    .phys_o (prg_phys_o)
  );

  bankmap_pat_xlat #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .OFS_W(PAT_OFS_W),
                     .WIN_W(PAT_WIN_W)) pat_i (
    .clk    (clk),
    .rst    (rst),
    .addr_i (pat_addr_i),
    .sel_i  (sel),
    .bank_i (bank),
    .phys_o (pat_phys_o)
  );

endmodule

// File: tb/bankmap_top_tb_top.sv
module bankmap_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic [7:0]  cpu_data_i = '0;
  logic [12:0] pat_addr_i = '0;
  logic [20:0] prg_phys_o;
  logic [17:0] pat_phys_o;
  logic        mirror_h_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  bankmap_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr_i (cpu_addr_i),
    .cpu_wr_i   (cpu_wr_i),
    .cpu_data_i (cpu_data_i),
    .pat_addr_i (pat_addr_i),
    .prg_phys_o (prg_phys_o),
    .pat_phys_o (pat_phys_o),
    .mirror_h_o (mirror_h_o)
  );

  typedef struct packed {
    logic [7:0]  sel;
    logic        is_pat;
    logic [15:0] addr;
    logic [7:0]  bank;
  } vec_t;

  localparam int NV = 25;
  // Bank registers hold 0x20 + index during the table walk
  localparam vec_t VECS [NV] = '{
    // R3 / R4: program windows, swap clear then set
    '{8'h00, 1'b0, 16'h8123, 8'h26},
    '{8'h00, 1'b0, 16'hA456, 8'h27},
    '{8'h00, 1'b0, 16'hC789, 8'h2F},
    '{8'h00, 1'b0, 16'hE001, 8'hFF},
    '{8'h40, 1'b0, 16'h8000, 8'h2F},
    '{8'h40, 1'b0, 16'hA00F, 8'h26},
    '{8'h40, 1'b0, 16'hC0F0, 8'h27},
    '{8'h40, 1'b0, 16'hFFFF, 8'hFF},
    // R5: paired pattern banking, no inversion
    '{8'h00, 1'b1, 16'h0003, 8'h20},
    '{8'h00, 1'b1, 16'h0455, 8'h21},
    '{8'h00, 1'b1, 16'h0811, 8'h21},
    '{8'h00, 1'b1, 16'h0C22, 8'h22},
    '{8'h00, 1'b1, 16'h1033, 8'h22},
    '{8'h00, 1'b1, 16'h1744, 8'h23},
    '{8'h00, 1'b1, 16'h1899, 8'h24},
    '{8'h00, 1'b1, 16'h1FFF, 8'h25},
    // R5: full 1 KB banking
    '{8'h20, 1'b1, 16'h0401, 8'h28},
    '{8'h20, 1'b1, 16'h0C02, 8'h29},
    // R6: inverted halves, paired
    '{8'h80, 1'b1, 16'h0005, 8'h22},
    '{8'h80, 1'b1, 16'h1006, 8'h20},
    '{8'h80, 1'b1, 16'h1407, 8'h21},
    '{8'h80, 1'b1, 16'h1C08, 8'h22},
    '{8'h80, 1'b1, 16'h0809, 8'h24},
    // R6: inverted halves, full banking
    '{8'hA0, 1'b1, 16'h140A, 8'h28},
    '{8'hA0, 1'b1, 16'h1C0B, 8'h29}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr_i = a;
    cpu_data_i = d;
    cpu_wr_i   = 1'b1;
    @(negedge clk);
    cpu_wr_i   = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] pa, input logic [12:0] ta);
    @(negedge clk);
    cpu_wr_i   = 1'b0;
    cpu_addr_i = pa;
    pat_addr_i = ta;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    lookup(16'h8000, 13'h0400);
    check("R1 prg", 32'(prg_phys_o), 32'h0);
    check("R1 pat", 32'(pat_phys_o), 32'(18'h00400 | (18'h01 << 10)));
    check("R1 mirror", 32'(mirror_h_o), 32'h0);
    lookup(16'hE000, 13'h0);
    check("R4 reset", 32'(prg_phys_o), 32'(21'hFF << 13));

    // R2: load every register, number 9 through an alias address
    for (int i = 0; i < 16; i++) begin
      cpu_write(16'h8000, 8'(i));
      cpu_write((i == 9) ? 16'h9FFF : 16'h8001, 8'h20 + 8'(i));
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      cpu_write(16'h8000, VECS[v].sel);
      if (VECS[v].is_pat) begin
        lookup(16'h0000, VECS[v].addr[12:0]);
        check((VECS[v].sel[5]) ? "R5/R2" : (VECS[v].sel[7] ? "R6" : "R5"),
              32'(pat_phys_o), 32'({VECS[v].bank, VECS[v].addr[9:0]}));
      end else begin
        lookup(VECS[v].addr, 13'h0);
        check((VECS[v].addr[14:13] == 2'd3) ? "R4" : "R3",
              32'(prg_phys_o), 32'({VECS[v].bank, VECS[v].addr[12:0]}));
      end
    end

    // R7: mirroring, including an alias of the decode
    cpu_write(16'hA000, 8'h01);
    check("R7 set", 32'(mirror_h_o), 32'h1);
    cpu_write(16'hBFFE, 8'hFE);
    check("R7 alias clear", 32'(mirror_h_o), 32'h0);
    cpu_write(16'hA000, 8'h03);
    check("R7 set again", 32'(mirror_h_o), 32'h1);

    // R8: non-decoded writes leave select, banks and mirroring alone
    cpu_write(16'h8000, 8'h06);
    cpu_write(16'hA001, 8'h00);
    cpu_write(16'hC000, 8'h55);
    cpu_write(16'hC001, 8'h55);
    cpu_write(16'hE000, 8'h55);
    cpu_write(16'hE001, 8'h55);
    cpu_write(16'h0001, 8'h55);
    cpu_write(16'h6000, 8'h00);
    cpu_write(16'h7FFF, 8'h55);
    lookup(16'h8010, 13'h0);
    check("R8 bank6/sel", 32'(prg_phys_o), 32'({8'h26, 13'h0010}));
    lookup(16'hC010, 13'h1C00);
    check("R8 bank15", 32'(prg_phys_o), 32'({8'h2F, 13'h0010}));
    check("R8 pat", 32'(pat_phys_o), 32'({8'h25, 10'h000}));
    check("R8 mirror", 32'(mirror_h_o), 32'h1);

    // R9: one-cycle latency: output still shows the previous lookup
    @(negedge clk);
    cpu_addr_i = 16'hA123;
    #1;
    check("R9 hold", 32'(prg_phys_o), 32'({8'h2F, 13'h0010}));
    @(negedge clk);
    check("R9 update", 32'(prg_phys_o), 32'({8'h27, 13'h0123}));

    // R10: paired bank wraps
    cpu_write(16'h8000, 8'h00);
    cpu_write(16'h8001, 8'hFF);
    lookup(16'h8000, 13'h0401);
    check("R10 wrap", 32'(pat_phys_o), 32'({8'h00, 10'h001}));
    lookup(16'h8000, 13'h0002);
    check("R10 base", 32'(pat_phys_o), 32'({8'hFF, 10'h002}));

    // R1: reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    lookup(16'h8000, 13'h1000);
    check("R1 re-reset prg", 32'(prg_phys_o), 32'h0);
    check("R1 re-reset pat", 32'(pat_phys_o), 32'h0);
    check("R1 re-reset mirror", 32'(mirror_h_o), 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule